// File: doc/BRIEF.md
# Micro-op Dispatch Bandwidth Controller

This block decides, in the same cycle an instruction is offered, whether that instruction may be dispatched. Each offered instruction carries a micro-op count and two flags: zero-latency and dependency-breaking. The block keeps two pieces of state, the slots still open in the current cycle and the micro-ops carried over from an earlier instruction that was too wide for one cycle. Three downstream agents are modelled as handshake inputs: a register-file allocator that reports a busy mask, a retire buffer that reports how many entries it has free, and a scheduler that reports ready or gives a refusal code.

When the instruction is accepted, the block raises a dispatch strobe. It also raises a slot-reserve request that carries the effective micro-op count, and it raises a register-allocate enable unless the instruction is both zero-latency and dependency-breaking. If bandwidth allows the instruction but a downstream agent refuses it, the block reports a single 2-bit stall cause chosen by fixed priority. When the cause is the scheduler, the scheduler's own refusal code is passed through.

Top module: `uop_dispatch_ctrl`

## Requirements
- R1: After reset the block starts a cycle with all DISP_W slots open and no carry-over. An instruction of any micro-op count that is offered first after reset is therefore accepted if the resources agree.
- R2: An instruction whose effective count is at most DISP_W dispatches only when the open slots are at least its count and all resources agree.
- R3: An instruction whose effective count exceeds DISP_W dispatches only when all DISP_W slots are open. The leftover (count minus DISP_W) becomes carry-over.
- R4: At every clock edge a new cycle begins. Open slots become DISP_W minus carry-over, or 0 if carry-over is at least DISP_W. Carry-over drops by DISP_W and saturates at 0. While carry-over is nonzero, nothing dispatches.
- R5: A micro-op count of 0 is treated as 1 for slots, for the retire check and for the reserve count.
- R6: A nonzero register-file busy mask blocks dispatch, and stall_cause reads 1.
- R7: A retire free count below the effective micro-op count blocks dispatch, and stall_cause reads 2. A free count equal to the effective count is enough.
- R8: A scheduler refusal blocks dispatch, and stall_cause reads 3. In that case stall_sched_code carries sched_code. In every other case stall_sched_code is 0.
- R9: When several resources refuse at once, the register file wins over the retire buffer, and the retire buffer wins over the scheduler.
- R10: With in_valid low, or when bandwidth alone blocks the instruction, stall_cause is 0 and no strobe is raised. Resources are not consulted in either case.
- R11: rsv_req equals dispatch, and rsv_uops equals the effective micro-op count whenever rsv_req is high.
- R12: reg_alloc_en is high exactly when dispatch is high and the instruction is not both zero-latency and dependency-breaking.
- R13: dispatch and every other output follow the inputs within the same cycle, with no register between inputs and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge starts a new dispatch cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_uops | input | UOP_W | Micro-op count of the offered instruction |
| in_zero_lat | input | 1 | Instruction is zero-latency |
| in_dep_break | input | 1 | Instruction breaks dependencies |
| rf_busy | input | NRF | One bit per register file that cannot allocate |
| rob_free | input | ROB_W | Free entries in the retire buffer |
| sched_ready | input | 1 | Scheduler accepts the instruction |
| sched_code | input | SCW | Scheduler refusal reason |
| dispatch | output | 1 | Instruction dispatched this cycle |
| rsv_req | output | 1 | Reserve retire-buffer entries |
| rsv_uops | output | UOP_W | Entries to reserve (effective count) |
| reg_alloc_en | output | 1 | Allocate destination registers |
| stall_cause | output | 2 | 0 none, 1 register file, 2 retire buffer, 3 scheduler |
| stall_sched_code | output | SCW | Forwarded scheduler reason when stall_cause is 3 |

## Verification
The bench aims first at the carry-over boundaries. These include an oversized instruction that leaves less than a full width, one that leaves exactly a full width or more, and the cycle when the leftover finally drains. A design that forgot to saturate would wrap the carry and block dispatch for many cycles. A design that let instructions slip in beside a pending carry would dispatch too early. A zero micro-op count is checked as a single slot; a design that got it wrong would reserve zero entries or pass an empty retire buffer. Priority is checked with every resource refusing at once, and cause reporting is checked while bandwidth is blocked. A design with a reversed order, or one that consulted resources too early, would report the wrong nonzero cause.

// File: rtl/uop_dispatch_ctrl.sv
module uop_dispatch_ctrl #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int NRF    = 2,
  parameter int ROB_W  = 6,
  parameter int SCW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [UOP_W-1:0] in_uops,
  input  logic             in_zero_lat,
  input  logic             in_dep_break,
  input  logic [NRF-1:0]   rf_busy,
  input  logic [ROB_W-1:0] rob_free,
  input  logic             sched_ready,
  input  logic [SCW-1:0]   sched_code,
  output logic             dispatch,
  output logic             rsv_req,
  output logic [UOP_W-1:0] rsv_uops,
  output logic             reg_alloc_en,
  output logic [1:0]       stall_cause,
  output logic [SCW-1:0]   stall_sched_code
);
  localparam int AW = $clog2(DISP_W + 1);
  localparam int CW = (UOP_W > AW) ? UOP_W : AW;
  localparam int RW = (UOP_W > ROB_W) ? UOP_W : ROB_W;
  localparam logic [UOP_W-1:0] WIDTH_U = UOP_W'(DISP_W);
  localparam logic [AW-1:0]    WIDTH_A = AW'(DISP_W);
  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_RF   = 2'd1;
  localparam logic [1:0] CAUSE_ROB  = 2'd2;
  localparam logic [1:0] CAUSE_SCH  = 2'd3;

  logic [AW-1:0]    avail_q, avail_n;
  logic [UOP_W-1:0] carry_q, carry_post, carry_n;
  logic [UOP_W-1:0] eff;
  logic             big, bw_ok, rf_ref, rob_ref, sch_ref, offered;

  assign eff     = (in_uops == '0) ? UOP_W'(1) : in_uops;
  assign big     = eff > WIDTH_U;
  assign bw_ok   = (carry_q == '0) &&
                   (big ? (avail_q == WIDTH_A) : (CW'(avail_q) >= CW'(eff)));
  assign offered = in_valid && bw_ok;

  assign rf_ref  = |rf_busy;
  assign rob_ref = RW'(rob_free) < RW'(eff);
  assign sch_ref = !sched_ready;

  always_comb begin
    stall_cause = CAUSE_NONE;
    if (offered) begin
      if (rf_ref)       stall_cause = CAUSE_RF;
      else if (rob_ref) stall_cause = CAUSE_ROB;
      else if (sch_ref) stall_cause = CAUSE_SCH;
    end
  end

  assign dispatch         = offered && !rf_ref && !rob_ref && !sch_ref;
  assign rsv_req          = dispatch;
  assign rsv_uops         = dispatch ? eff : '0;
  assign reg_alloc_en     = dispatch && !(in_zero_lat && in_dep_break);
  assign stall_sched_code = (stall_cause == CAUSE_SCH) ? sched_code : '0;

  assign carry_post = (dispatch && big) ? (eff - WIDTH_U) : carry_q;

  always_comb begin
    if (carry_post >= WIDTH_U) begin
      avail_n = '0;
      carry_n = carry_post - WIDTH_U;
    end else begin
      avail_n = WIDTH_A - AW'(carry_post);
      carry_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail_q <= WIDTH_A;
      carry_q <= '0;
    end else begin
      avail_q <= avail_n;
      carry_q <= carry_n;
    end
  end
endmodule

module uop_dispatch_ctrl_chk #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int NRF    = 2,
  parameter int ROB_W  = 6,
  parameter int SCW    = 3,
  parameter int AW     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [UOP_W-1:0] in_uops,
  input logic             in_zero_lat,
  input logic             in_dep_break,
  input logic [NRF-1:0]   rf_busy,
  input logic [ROB_W-1:0] rob_free,
  input logic             dispatch,
  input logic             rsv_req,
  input logic [UOP_W-1:0] rsv_uops,
  input logic             reg_alloc_en,
  input logic [1:0]       stall_cause,
  input logic [SCW-1:0]   stall_sched_code,
  input logic [AW-1:0]    avail_q,
  input logic [UOP_W-1:0] carry_q
);
  // R10
  disp_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> in_valid);
  // R4
  carry_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_q != '0) |-> (avail_q == '0 && !dispatch));
  // R3
  wide_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && in_uops > UOP_W'(DISP_W)) |-> (32'(avail_q) == DISP_W));
  // R3
  wide_sets_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && in_uops > UOP_W'(2 * DISP_W)) |=> (carry_q != '0));
  // R6
  rf_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_busy != '0) |-> !dispatch);
  // R7
  rob_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch) |-> (32'(rob_free) >= 32'(rsv_uops) && rsv_uops != '0));
  // R9
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cause >= 2'd2) |-> (rf_busy == '0));
  // R8
  code_only_sched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cause != 2'd3) |-> (stall_sched_code == '0));
  // R11
  rsv_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_req == dispatch);
  // R12
  alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_alloc_en |-> (dispatch && !(in_zero_lat && in_dep_break)));
  // R13
  cause_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cause != 2'd0) |-> !dispatch);
endmodule

bind uop_dispatch_ctrl uop_dispatch_ctrl_chk #(
  .DISP_W(DISP_W), .UOP_W(UOP_W), .NRF(NRF), .ROB_W(ROB_W), .SCW(SCW),
  .AW($clog2(DISP_W + 1))
) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
  .in_zero_lat(in_zero_lat), .in_dep_break(in_dep_break),
  .rf_busy(rf_busy), .rob_free(rob_free), .dispatch(dispatch),
  .rsv_req(rsv_req), .rsv_uops(rsv_uops), .reg_alloc_en(reg_alloc_en),
  .stall_cause(stall_cause), .stall_sched_code(stall_sched_code),
  .avail_q(avail_q), .carry_q(carry_q)
);

// File: tb/test_uop_dispatch_ctrl.sv
module test_uop_dispatch_ctrl;
  localparam int W = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_uops = '0;
  logic       in_zero_lat = 1'b0;
  logic       in_dep_break = 1'b0;
  logic [1:0] rf_busy = '0;
  logic [5:0] rob_free = 6'd63;
  logic       sched_ready = 1'b1;
  logic [2:0] sched_code = '0;
  logic       dispatch, rsv_req, reg_alloc_en;
  logic [3:0] rsv_uops;
  logic [1:0] stall_cause;
  logic [2:0] stall_sched_code;

  int checks = 0;
  int fails = 0;
  int m_avail = W;
  int m_carry = 0;

  always #10 clk = ~clk;

  uop_dispatch_ctrl i_uop_dispatch_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
    .in_zero_lat(in_zero_lat), .in_dep_break(in_dep_break),
    .rf_busy(rf_busy), .rob_free(rob_free), .sched_ready(sched_ready),
    .sched_code(sched_code), .dispatch(dispatch), .rsv_req(rsv_req),
    .rsv_uops(rsv_uops), .reg_alloc_en(reg_alloc_en),
    .stall_cause(stall_cause), .stall_sched_code(stall_sched_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff_of(input int u);
    return (u == 0) ? 1 : u;
  endfunction

  function automatic bit bw_of(input int av, input int ca, input int e);
    if (ca != 0) return 1'b0;
    return (e > W) ? (av == W) : (av >= e);
  endfunction

  task automatic step(input bit v, input int u, input bit zl, input bit db,
                      input int rf, input int rob, input bit sr, input int sc);
    int e, ecause, ecode, ndisp;
    bit bw, r_rf, r_rob, r_sc;
    string dtag, ctag;
    @(negedge clk);
    in_valid = v; in_uops = 4'(u); in_zero_lat = zl; in_dep_break = db;
    rf_busy = 2'(rf); rob_free = 6'(rob); sched_ready = sr; sched_code = 3'(sc);
    e = eff_of(u);
    bw = bw_of(m_avail, m_carry, e);
    r_rf = (rf != 0); r_rob = (rob < e); r_sc = !sr;
    ecause = 0;
    if (v && bw) begin
      if (r_rf) ecause = 1;
      else if (r_rob) ecause = 2;
      else if (r_sc) ecause = 3;
    end
    ndisp = (v && bw && ecause == 0) ? 1 : 0;
    ecode = (ecause == 3) ? sc : 0;
    if (!v) dtag = "R10";
    else if (m_carry != 0) dtag = "R4";
    else if (e > W) dtag = "R3";
    else if (u == 0) dtag = "R5";
    else dtag = "R2";
    if (int'(r_rf) + int'(r_rob) + int'(r_sc) > 1) ctag = "R9";
    else if (r_rf) ctag = "R6";
    else if (r_rob) ctag = "R7";
    else ctag = "R8";
    if (!(v && bw)) ctag = "R10";
    #5;
    chk(int'(dispatch) == ndisp, {dtag, " R13 dispatch"}, int'(dispatch), ndisp);
    chk(int'(stall_cause) == ecause, {ctag, " stall_cause"}, int'(stall_cause), ecause);
    chk(int'(stall_sched_code) == ecode, "R8 stall_sched_code", int'(stall_sched_code), ecode);
    chk(rsv_req == dispatch, "R11 rsv_req", int'(rsv_req), int'(dispatch));
    if (ndisp == 1) begin
      chk(int'(rsv_uops) == e, (u == 0) ? "R5 rsv_uops" : "R11 rsv_uops", int'(rsv_uops), e);
      chk(int'(reg_alloc_en) == int'(!(zl && db)), "R12 reg_alloc_en",
          int'(reg_alloc_en), int'(!(zl && db)));
    end else begin
      chk(reg_alloc_en == 1'b0, "R12 reg_alloc_en idle", int'(reg_alloc_en), 0);
    end
    if (ndisp == 1 && e > W) m_carry = e - W;
    if (m_carry >= W) begin m_avail = 0; m_carry = m_carry - W; end
    else begin m_avail = W - m_carry; m_carry = 0; end
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, then a wide instruction takes the full empty cycle
    step(0, 3, 0, 0, 0, 63, 1, 0);
    step(1, 6, 0, 0, 0, 63, 1, 0);
    // R10: bandwidth blocks (2 open, 3 asked) while rf busy: cause stays 0
    step(1, 3, 0, 0, 1, 63, 1, 0);
    step(1, 3, 0, 0, 0, 63, 1, 0);
    // R4: carry of 8 drains over two cycles
    step(1, 12, 0, 0, 0, 63, 1, 0);
    step(1, 1, 0, 0, 0, 63, 1, 0);
    step(1, 1, 0, 0, 0, 63, 1, 0);
    step(1, 4, 0, 0, 0, 63, 1, 0);
    // R3: leftover exactly W
    step(1, 8, 0, 0, 0, 63, 1, 0);
    step(1, 1, 0, 0, 0, 63, 1, 0);
    step(1, 1, 0, 0, 0, 63, 1, 0);
    // R5 R12: zero count, zero-latency dependency-breaking
    step(1, 0, 1, 1, 0, 63, 1, 0);
    step(1, 2, 1, 0, 0, 63, 1, 0);
    // R9 priority
    step(1, 2, 0, 0, 2, 0, 0, 5);
    step(1, 2, 0, 0, 0, 1, 0, 5);
    step(1, 2, 0, 0, 0, 63, 0, 6);
    // R7 boundary
    step(1, 3, 0, 0, 0, 3, 1, 0);
    step(1, 3, 0, 0, 0, 2, 1, 0);
    step(1, 0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 5) != 0, $urandom % 10, $urandom % 2, $urandom % 2,
           (($urandom % 7) == 0) ? 1 + $urandom % 3 : 0,
           $urandom % 16, ($urandom % 6) != 0, $urandom % 8);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule